// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block is the recovery engine a bus master starts when it finds the I2C lines stuck. It lets go of both lines and first checks that the clock line can go high at all. If the clock line stays low, no clocking is tried. The block stops at once and asks for a hardware reset. If the data line is stuck low, the block drives a series of clock pulses on SCL with SDA left released. It samples SDA near the end of each high phase and stops pulsing as soon as a sample reads high. At most nine pulses are issued.

A recovery that frees SDA ends with a STOP condition and then reports success. If SDA is still low after the ninth pulse, the block reports failure and raises the hardware-reset request. It does the same if the clock line is held low while it tries to pulse. The line outputs are open-drain enables: a 1 means pull the line low. The line inputs must already be synchronised to `clk`. Results stay visible until the next start.

Top module: `i2c_bus_recover`

## Requirements
- R1: After reset, `scl_oe_o`, `sda_oe_o`, `done_o`, `success_o`, `hw_reset_req_o` are 0 and `pulse_count_o` is 0.
- R2: If `scl_in` stays low for STUCK_TIMEOUT clocks after a start, no pulse is driven and `done_o` and `hw_reset_req_o` rise exactly STUCK_TIMEOUT cycles after the start edge, with `pulse_count_o` = 0 and `success_o` = 0.
- R3: If both lines read high when checked, the block issues no recovery pulse, performs only the STOP, and ends with `success_o` = 1 and `pulse_count_o` = 0.
- R4: While the block is checking or pulsing, `sda_oe_o` is 0 (SDA released).
- R5: Each pulse drives SCL low for HALF_PERIOD clocks and then releases it for HALF_PERIOD clocks of SCL-high time. SDA is sampled on the last clock of the high time. A high sample ends the pulsing, so a device that frees SDA on pulse K gives `pulse_count_o` = K.
- R6: At most MAX_PULSES (9) pulses are issued. If SDA is still low at the ninth sample, the result is `hw_reset_req_o` = 1, `success_o` = 0 and `pulse_count_o` = 9.
- R7: After a release, a STOP is generated (SCL low with SDA low, SCL released, then SDA released while SCL is high) before `done_o` and `success_o` rise.
- R8: A successful recovery after K pulses raises `done_o` 1 + 2·K·HALF_PERIOD + 3·HALF_PERIOD cycles after the start edge. A nine-pulse failure raises it 1 + 18·HALF_PERIOD cycles after the start edge.
- R9: If SCL is held low during a pulse's high time for STUCK_TIMEOUT clocks, the block fails with `hw_reset_req_o` = 1. The pulse in progress is included in `pulse_count_o`.
- R10: A `start_i` pulse while a recovery is running is ignored and does not change its timing or result.
- R11: `done_o`, `success_o`, `hw_reset_req_o` and `pulse_count_o` hold their values until the next accepted start, which clears them. `success_o` and `hw_reset_req_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin recovery |
| scl_in | input | 1 | Synchronised SCL line level |
| sda_in | input | 1 | Synchronised SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| done_o | output | 1 | Recovery finished (held) |
| success_o | output | 1 | Bus freed and STOP sent (held) |
| hw_reset_req_o | output | 1 | Hardware reset needed (held) |
| pulse_count_o | output | 4 | Pulses issued, 0 to 9 |

## Verification
The results appear together on the cycle `done_o` rises. That is STOP_TIMEOUT-free arithmetic: STUCK_TIMEOUT cycles after the start edge when SCL is stuck, 1+2·K·HALF_PERIOD+3·HALF_PERIOD after a release on pulse K, and 1+18·HALF_PERIOD after nine failed pulses. The bench counts rising clock edges from the start edge and samples on each falling edge. It compares the cycle in which `done_o` is first seen against the formula, and reads the result outputs in that same cycle. A bus model in the bench counts the SCL rises made with SDA released and watches for the STOP edge. These observations are compared with the expected pulse count and outcome.

// File: rtl/i2c_rcv_pkg.sv
// Package: shared state encoding for the bus-clear recovery sequencer.
// Assumes: nothing; it holds types only.
package i2c_rcv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CHECK  = 3'd1,
        ST_LOW    = 3'd2,
        ST_HIGH   = 3'd3,
        ST_STOP_A = 3'd4,
        ST_STOP_B = 3'd5,
        ST_STOP_C = 3'd6
    } rcv_state_t;

endpackage

// File: rtl/rcv_phase_timer.sv
// Module: counts clocks within one phase and flags the last clock of it.
// Assumes: the phase lasts HALF_PERIOD clocks in which run_i is high.
//          clear_i zeroes the count, and the count also restarts by itself
//          after each phase end.
module rcv_phase_timer #(
    parameter int HALF_PERIOD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic phase_end_o
);
    localparam int TW = $clog2(HALF_PERIOD + 1);

    logic [TW-1:0] cnt_q;

    assign phase_end_o = run_i && (cnt_q == TW'(HALF_PERIOD - 1));

    // Phase counter: restarts on clear or at the end of a phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i || phase_end_o) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= cnt_q + TW'(1);
        end
    end
endmodule

// File: rtl/rcv_stuck_watch.sv
// Module: detects a line that stays low for TIMEOUT consecutive clocks
//         while it is meant to be released.
// Assumes: arm_i is high only while the block has released the line.
module rcv_stuck_watch #(
    parameter int TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic line_low_i,
    output logic stuck_o
);
    localparam int SW = $clog2(TIMEOUT + 1);

    logic [SW-1:0] low_q;

    assign stuck_o = arm_i && line_low_i && (low_q == SW'(TIMEOUT - 1));

    // Low-time counter: runs while armed and the line reads low.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm_i || !line_low_i) begin
            low_q <= '0;
        end else if (!stuck_o) begin
            low_q <= low_q + SW'(1);
        end
    end
endmodule

// File: rtl/rcv_pulse_counter.sv
// Module: counts the recovery pulses issued and flags when the cap is reached.
// Assumes: inc_i is high for one clock per pulse and the count never passes MAX.
module rcv_pulse_counter #(
    parameter int MAX = 9,
    parameter int CW  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          inc_i,
    output logic [CW-1:0] count_o,
    output logic          at_max_o
);
    assign at_max_o = (count_o == CW'(MAX));

    // Pulse count: cleared on a new start, incremented per issued pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            count_o <= '0;
        end else if (inc_i && !at_max_o) begin
            count_o <= count_o + CW'(1);
        end
    end
endmodule

// File: rtl/i2c_bus_recover.sv
// Module: I2C bus-clear recovery sequencer (top).
//   It checks that SCL can go high. If SDA is low it clocks SCL up to
//   MAX_PULSES times and exits early once SDA reads high, then sends a
//   STOP. A stuck clock or an unfreed SDA raises a hardware-reset request.
// Assumes: scl_in and sda_in are already synchronised to clk; the line
//          outputs drive open-drain pads, where 1 pulls the line low.
module i2c_bus_recover
    import i2c_rcv_pkg::*;
#(
    parameter int HALF_PERIOD   = 250,
    parameter int STUCK_TIMEOUT = 5000,
    parameter int MAX_PULSES    = 9,
    parameter int CNT_W         = $clog2(MAX_PULSES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_oe_o,
    output logic             sda_oe_o,
    output logic             done_o,
    output logic             success_o,
    output logic             hw_reset_req_o,
    output logic [CNT_W-1:0] pulse_count_o
);
    rcv_state_t state_q, state_d;
    logic phase_end, stuck, at_max;
    logic timer_clear, timer_run, watch_arm;
    logic accept, fin_ok, fin_bad, pulse_inc;

    assign accept      = (state_q == ST_IDLE) && start_i;
    assign timer_clear = (state_q == ST_IDLE) || (state_q == ST_CHECK);
    assign timer_run   = (state_q == ST_LOW) || (state_q == ST_STOP_A) ||
                         (state_q == ST_STOP_B) || (state_q == ST_STOP_C) ||
                         ((state_q == ST_HIGH) && scl_in);
    assign watch_arm   = (state_q == ST_CHECK) || (state_q == ST_HIGH);
    assign pulse_inc   = (state_q == ST_LOW) && phase_end;

    rcv_phase_timer #(.HALF_PERIOD(HALF_PERIOD)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (timer_clear),
        .run_i      (timer_run),
        .phase_end_o(phase_end)
    );

    rcv_stuck_watch #(.TIMEOUT(STUCK_TIMEOUT)) u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (watch_arm),
        .line_low_i(!scl_in),
        .stuck_o   (stuck)
    );

    rcv_pulse_counter #(.MAX(MAX_PULSES), .CW(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .inc_i   (pulse_inc),
        .count_o (pulse_count_o),
        .at_max_o(at_max)
    );

    // Next-state decision for the check, pulse and STOP sequence.
    always_comb begin
        state_d = state_q;
        fin_ok  = 1'b0;
        fin_bad = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_CHECK;
            ST_CHECK: begin
                if (stuck) begin
                    fin_bad = 1'b1;
                    state_d = ST_IDLE;
                end else if (scl_in) begin
                    state_d = sda_in ? ST_STOP_A : ST_LOW;
                end
            end
            ST_LOW: if (phase_end) state_d = ST_HIGH;
            ST_HIGH: begin
                if (stuck) begin
                    fin_bad = 1'b1;
                    state_d = ST_IDLE;
                end else if (phase_end) begin
                    if (sda_in) begin
                        state_d = ST_STOP_A;
                    end else if (at_max) begin
                        fin_bad = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_LOW;
                    end
                end
            end
            ST_STOP_A: if (phase_end) state_d = ST_STOP_B;
            ST_STOP_B: if (phase_end) state_d = ST_STOP_C;
            ST_STOP_C: begin
                if (phase_end) begin
                    fin_ok  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and registered open-drain enables decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            scl_oe_o <= 1'b0;
            sda_oe_o <= 1'b0;
        end else begin
            state_q  <= state_d;
            scl_oe_o <= (state_d == ST_LOW) || (state_d == ST_STOP_A);
            sda_oe_o <= (state_d == ST_STOP_A) || (state_d == ST_STOP_B);
        end
    end

    // Result flags: cleared on an accepted start, set when a run finishes.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            done_o         <= 1'b0;
            success_o      <= 1'b0;
            hw_reset_req_o <= 1'b0;
        end else if (fin_ok || fin_bad) begin
            done_o         <= 1'b1;
            success_o      <= fin_ok;
            hw_reset_req_o <= fin_bad;
        end
    end
endmodule

// File: rtl/i2c_bus_recover_chk.sv
// Module: property checker for the recovery sequencer, bound to the top.
// Assumes: state_i carries the top's state encoding from i2c_rcv_pkg.
module i2c_bus_recover_chk #(
    parameter int MAX_PULSES = 9,
    parameter int CNT_W      = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             scl_oe_o,
    input logic             sda_oe_o,
    input logic             done_o,
    input logic             success_o,
    input logic             hw_reset_req_o,
    input logic [CNT_W-1:0] pulse_count_o,
    input logic [2:0]       state_i
);
    import i2c_rcv_pkg::*;

    p_req_has_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hw_reset_req_o |-> done_o);

    p_sda_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_CHECK || state_i == ST_LOW || state_i == ST_HIGH) |-> !sda_oe_o);

    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (pulse_count_o == $past(pulse_count_o)) ||
                     (pulse_count_o == $past(pulse_count_o) + CNT_W'(1)));

    p_count_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_count_o <= CNT_W'(MAX_PULSES));

    p_stop_before_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(success_o) |-> !$past(sda_oe_o) && !$past(scl_oe_o));

    p_done_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !scl_oe_o && !sda_oe_o);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o && $stable(success_o) &&
                                 $stable(hw_reset_req_o) && $stable(pulse_count_o));

    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(success_o && hw_reset_req_o));
endmodule

bind i2c_bus_recover i2c_bus_recover_chk #(.MAX_PULSES(MAX_PULSES), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .scl_oe_o      (scl_oe_o),
    .sda_oe_o      (sda_oe_o),
    .done_o        (done_o),
    .success_o     (success_o),
    .hw_reset_req_o(hw_reset_req_o),
    .pulse_count_o (pulse_count_o),
    .state_i       (state_q)
);

// File: tb/sim_i2c_bus_recover.sv
// Bench: a bus model with a stuck target device, plus directed and seeded-random trials.
module sim_i2c_bus_recover;
    localparam int HP  = 4;
    localparam int TO  = 20;
    localparam int MAX = 9;
    localparam int CW  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic scl_oe, sda_oe, done, success, hw_req;
    logic [CW-1:0] pcount;

    // Bus model state
    logic scl_stuck = 1'b0;
    int   rel_after = 0;     // device frees SDA after this many pulse rises
    int   stick_at  = 0;     // hold SCL low after this pulse's fall (0 = never)
    int   rises = 0;
    logic stop_seen = 1'b0;
    logic sda_oe_d = 1'b0;

    wire scl_bus = !scl_oe && !scl_stuck;
    wire sda_bus = !sda_oe && !(rises < rel_after);

    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    i2c_bus_recover #(.HALF_PERIOD(HP), .STUCK_TIMEOUT(TO), .MAX_PULSES(MAX)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .scl_in(scl_bus), .sda_in(sda_bus),
        .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .done_o(done), .success_o(success),
        .hw_reset_req_o(hw_req), .pulse_count_o(pcount)
    );

    // Count SCL rises made while SDA is released (recovery pulses).
    always @(posedge scl_bus) if (!sda_oe) rises = rises + 1;

    // Target may seize SCL at the fall of a chosen pulse.
    always @(negedge scl_bus) if (stick_at != 0 && rises == stick_at) scl_stuck = 1'b1;

    // STOP monitor: SDA let go by the master while SCL is high.
    always @(posedge clk) begin
        if (sda_oe_d && !sda_oe && scl_bus) stop_seen <= 1'b1;
        sda_oe_d <= sda_oe;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_latency(input int k, input bit fail9, input bit sstuck);
        if (sstuck) return TO;
        if (fail9)  return 1 + 2 * MAX * HP;
        return 1 + 2 * k * HP + 3 * HP;
    endfunction

    // One trial: k = release pulse (>MAX means never), j = mid stick pulse, s = stuck at start.
    task automatic trial(input int k, input int j, input bit s, input bit extra_start);
        int cyc = 0;
        bit fail9, mid, ok;
        int exp_cnt, exp_rises, lat;
        @(negedge clk);
        scl_stuck = s; rel_after = k; stick_at = j; rises = 0; stop_seen = 1'b0;
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        while (1) begin
            @(posedge clk); cyc++;
            if (extra_start && cyc == 5) begin #1 start = 1'b1; end
            else if (extra_start && cyc == 6) begin #1 start = 1'b0; end
            @(negedge clk);
            if (done || cyc > 2000) break;
        end
        mid   = !s && (j != 0);
        fail9 = !s && !mid && (k > MAX);
        ok    = !s && !mid && !fail9;
        exp_cnt   = s ? 0 : mid ? j + 1 : fail9 ? MAX : k;
        exp_rises = s ? 0 : mid ? j : exp_cnt;
        check("R2/R6/R9 done reached", int'(done), 1);
        if (!mid) begin
            lat = exp_latency(k, fail9, s);
            check(extra_start ? "R10 latency with ignored start" : "R8 done latency", cyc, lat);
        end
        check(s ? "R2 success" : k == 0 ? "R3 success" : "R5 success", int'(success), int'(ok));
        check(mid ? "R9 hw_reset_req" : "R6 hw_reset_req", int'(hw_req), int'(!ok));
        check(k == 0 ? "R3 pulse count" : "R5 pulse count", int'(pcount), exp_cnt);
        check("R5 observed pulses", rises, exp_rises);
        check("R7 STOP seen", int'(stop_seen), int'(ok));
        repeat (3) @(negedge clk);
        check("R11 results held", int'({done, success, hw_req, pcount}),
              int'({1'b1, ok, !ok, 4'(exp_cnt)}));
        scl_stuck = 1'b0; stick_at = 0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset outputs", int'({scl_oe, sda_oe, done, success, hw_req, pcount}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle outputs", int'({scl_oe, sda_oe, done, success, hw_req, pcount}), 0);
        trial(0, 0, 1'b0, 1'b0);   // R3 lines already free
        trial(1, 0, 1'b0, 1'b0);   // R5 first pulse frees
        trial(9, 0, 1'b0, 1'b0);   // R5 release on last allowed pulse
        trial(10, 0, 1'b0, 1'b0);  // R6 never freed
        trial(3, 0, 1'b1, 1'b0);   // R2 SCL stuck at start
        trial(10, 4, 1'b0, 1'b0);  // R9 SCL seized mid-recovery
        trial(5, 0, 1'b0, 1'b1);   // R10 start during run ignored
        for (int i = 0; i < 30; i++) begin
            int k, j;
            bit s;
            k = int'($urandom_range(0, 11));
            s = ($urandom_range(0, 7) == 0);
            j = 0;
            if (!s && k >= 2 && $urandom_range(0, 3) == 0)
                j = int'($urandom_range(1, (k > MAX ? MAX : k) - 1));
            trial(k, j, s, $urandom_range(0, 4) == 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule